// File: doc/BRIEF.md
# Receive Xon/Xoff Flow Control Matcher

This block sits between a UART receiver and its receive FIFO. Every character the receiver delivers is compared against four programmable control values: two resume values and two pause values. In single mode only the first value of each kind is used. In double mode a control match needs two consecutive characters that equal the first and then the second value. A pause match raises a suspend request toward the transmitter and sets a status flag. The flag can also drive an interrupt. A resume match withdraws the request and clears the flag. Matched control characters are consumed and never reach the FIFO write port. All other characters are forwarded unchanged.

The suspend request does not reach the transmitter at once. The `tx_suspend` output follows the internal request only on clock edges where the transmitter reports, through `tx_at_boundary`, that it sits at a start-bit boundary. A character already being shifted out is therefore never cut short. The character width used for comparison is set by a word-length code, and the bits above the selected width are ignored. The receiver is expected to strobe characters at least two clock cycles apart. This always holds at serial rates.

Top module: `xonxoff_matcher`

## Requirements
- R1: After reset the four control registers hold 0x00, and `fifo_wr`, `tx_suspend`, `xoff_flag` and `irq` are low.
- R2: In single mode (`fc_mode`=1), a character that matches control register 2 (pause, first) is dropped. It sets `xoff_flag` and raises the suspend request.
- R3: In single mode, a character that matches control register 0 (resume, first) is dropped. It clears `xoff_flag` and withdraws the suspend request.
- R4: In double mode (`fc_mode`=2), a character matching register 2 followed by one matching register 3 acts as a pause. A character matching register 0 followed by one matching register 1 acts as a resume. Both characters of the pair are dropped.
- R5: In double mode, when a held first character is followed by a character that does not complete its pair, the held character is written on the cycle after the strobe. The new character is written one cycle later, unless it is itself a first control value, in which case it is held in turn.
- R6: `tx_suspend` changes only on the clock edge that follows a cycle with `tx_at_boundary` high, or when flow control is turned off.
- R7: With `fc_mode` 0 or 3, every character is written to the FIFO and `tx_suspend` is low. `xoff_flag` keeps its value.
- R8: `irq` is high exactly while `xoff_flag` and `xoff_irq_en` are both high.
- R9: Comparison uses only the low 5, 6, 7 or 8 bits for `wlen` codes 0, 1, 2 or 3. Forwarded characters keep all 8 bits.
- R10: When one character matches both a pause value and a resume value in the same position, the pause wins.
- R11: A forwarded character appears on `fifo_wr`/`fifo_data` on the cycle after its `rx_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received character |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 2 | Register index: 0 resume-1, 1 resume-2, 2 pause-1, 3 pause-2 |
| reg_wdata | input | 8 | Register write value |
| fc_mode | input | 2 | 0 off, 1 single, 2 double, 3 off |
| wlen | input | 2 | Compare width code: 0=5, 1=6, 2=7, 3=8 bits |
| xoff_irq_en | input | 1 | Enables the interrupt from the pause flag |
| tx_at_boundary | input | 1 | Transmitter is at a start-bit boundary |
| tx_suspend | output | 1 | Hold-off request to the transmitter |
| fifo_wr | output | 1 | Receive FIFO write enable |
| fifo_data | output | 8 | Receive FIFO write data |
| xoff_flag | output | 1 | Pause status flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is in double mode: a held first character is broken by a second character that is itself a first control value. Here the block has to emit one character, keep holding another, and still recognise the pair that follows. The vector table drives exactly that sequence: pause-1, pause-1, pause-2. It then checks one forwarded byte, no second write, and a pause taking effect. The boundary gating is reached by holding `tx_at_boundary` low across a pause match. The bench then confirms that `tx_suspend` stays low until a single boundary pulse.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
   typedef enum logic [1:0] {
      FC_OFF    = 2'd0,
      FC_SINGLE = 2'd1,
      FC_DOUBLE = 2'd2,
      FC_RSVD   = 2'd3
   } fc_mode_e;

   localparam int unsigned IDX_ON1  = 0;
   localparam int unsigned IDX_ON2  = 1;
   localparam int unsigned IDX_OFF1 = 2;
   localparam int unsigned IDX_OFF2 = 3;
   localparam int unsigned NUM_CTRL = 4;

   typedef struct packed {
      logic on1;
      logic on2;
      logic off1;
      logic off2;
   } hit_t;
endpackage

// File: rtl/xfc_char_regs.sv
module xfc_char_regs #(
   parameter int unsigned CHAR_W = 8,
   parameter int unsigned NREGS  = 4,
   localparam int unsigned SEL_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [CHAR_W-1:0] wr_data,
   output logic [CHAR_W-1:0] val [NREGS]
);
   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      logic [CHAR_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_sel == SEL_W'(i)))
            q <= wr_data;
      end
      assign val[i] = q;
   end
endmodule

// File: rtl/xfc_cmp.sv
module xfc_cmp
   import xfc_pkg::*;
#(
   parameter int unsigned CHAR_W = 8,
   localparam int unsigned MIN_BITS = CHAR_W - 3
) (
   input  logic [CHAR_W-1:0] ch,
   input  logic [1:0]        wlen,
   input  logic [CHAR_W-1:0] val [NUM_CTRL],
   output hit_t              hit
);
   logic [CHAR_W-1:0]   mask;
   logic [NUM_CTRL-1:0] hv;

   for (genvar b = 0; b < CHAR_W; b++) begin : g_mask
      assign mask[b] = (b < (MIN_BITS + int'(wlen)));
   end

   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
      assign hv[i] = (((ch ^ val[i]) & mask) == '0);
   end

   assign hit.on1  = hv[IDX_ON1];
   assign hit.on2  = hv[IDX_ON2];
   assign hit.off1 = hv[IDX_OFF1];
   assign hit.off2 = hv[IDX_OFF2];
endmodule

// File: rtl/xfc_seq.sv
module xfc_seq
   import xfc_pkg::*;
#(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  fc_mode_e          mode,
   input  hit_t              hit,
   output logic              wr,
   output logic [CHAR_W-1:0] wdata,
   output logic              susp_req,
   output logic              flag
);
   logic              pend_vld, pend_on, pend_off;
   logic [CHAR_W-1:0] pend_data;
   logic              spill_vld;
   logic [CHAR_W-1:0] spill_data;
   logic              is_first;

   assign is_first = hit.on1 | hit.off1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr         <= 1'b0;
         wdata      <= '0;
         susp_req   <= 1'b0;
         flag       <= 1'b0;
         pend_vld   <= 1'b0;
         pend_on    <= 1'b0;
         pend_off   <= 1'b0;
         pend_data  <= '0;
         spill_vld  <= 1'b0;
         spill_data <= '0;
      end else begin
         wr <= 1'b0;
         if (spill_vld) begin
            wr        <= 1'b1;
            wdata     <= spill_data;
            spill_vld <= 1'b0;
         end
         if (mode != FC_DOUBLE)
            pend_vld <= 1'b0;
         if (mode == FC_OFF || mode == FC_RSVD)
            susp_req <= 1'b0;
         if (rx_valid) begin
            unique case (mode)
               FC_SINGLE: begin
                  if (hit.off1) begin
                     susp_req <= 1'b1;
                     flag     <= 1'b1;
                  end else if (hit.on1) begin
                     susp_req <= 1'b0;
                     flag     <= 1'b0;
                  end else begin
                     wr    <= 1'b1;
                     wdata <= rx_data;
                  end
               end
               FC_DOUBLE: begin
                  if (pend_vld && pend_off && hit.off2) begin
                     pend_vld <= 1'b0;
                     susp_req <= 1'b1;
                     flag     <= 1'b1;
                  end else if (pend_vld && pend_on && hit.on2) begin
                     pend_vld <= 1'b0;
                     susp_req <= 1'b0;
                     flag     <= 1'b0;
                  end else begin
                     if (pend_vld) begin
                        wr    <= 1'b1;
                        wdata <= pend_data;
                     end
                     if (is_first) begin
                        pend_vld  <= 1'b1;
                        pend_on   <= hit.on1;
                        pend_off  <= hit.off1;
                        pend_data <= rx_data;
                     end else begin
                        pend_vld <= 1'b0;
                        if (pend_vld) begin
                           spill_vld  <= 1'b1;
                           spill_data <= rx_data;
                        end else begin
                           wr    <= 1'b1;
                           wdata <= rx_data;
                        end
                     end
                  end
               end
               default: begin
                  wr    <= 1'b1;
                  wdata <= rx_data;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/xonxoff_matcher.sv
module xonxoff_matcher
   import xfc_pkg::*;
#(
   parameter int unsigned CHAR_W          = 8,
   parameter bit          GATE_AT_BOUNDARY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [CHAR_W-1:0] reg_wdata,
   input  logic [1:0]        fc_mode,
   input  logic [1:0]        wlen,
   input  logic              xoff_irq_en,
   input  logic              tx_at_boundary,
   output logic              tx_suspend,
   output logic              fifo_wr,
   output logic [CHAR_W-1:0] fifo_data,
   output logic              xoff_flag,
   output logic              irq
);
   if (CHAR_W < 5) begin : g_chk_w
      $error("CHAR_W must be at least 5");
   end

   logic [CHAR_W-1:0] reg_val [NUM_CTRL];
   hit_t              hit;
   fc_mode_e          mode;
   logic              susp_req;
   logic              fc_on;
   logic              susp_q;

   assign mode  = fc_mode_e'(fc_mode);
   assign fc_on = (mode == FC_SINGLE) || (mode == FC_DOUBLE);

   xfc_char_regs #(.CHAR_W(CHAR_W), .NREGS(NUM_CTRL)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_sel  (reg_sel),
      .wr_data (reg_wdata),
      .val     (reg_val)
   );

   xfc_cmp #(.CHAR_W(CHAR_W)) u_cmp (
      .ch   (rx_data),
      .wlen (wlen),
      .val  (reg_val),
      .hit  (hit)
   );

   xfc_seq #(.CHAR_W(CHAR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .mode     (mode),
      .hit      (hit),
      .wr       (fifo_wr),
      .wdata    (fifo_data),
      .susp_req (susp_req),
      .flag     (xoff_flag)
   );

   if (GATE_AT_BOUNDARY) begin : g_gated
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            susp_q <= 1'b0;
         else if (!fc_on)
            susp_q <= 1'b0;
         else if (tx_at_boundary)
            susp_q <= susp_req;
      end
   end else begin : g_direct
      assign susp_q = susp_req;
   end

   assign tx_suspend = susp_q & fc_on;
   assign irq        = xoff_flag & xoff_irq_en;
endmodule

// File: rtl/xonxoff_matcher_chk.sv
module xonxoff_matcher_chk #(
   parameter int unsigned CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [CHAR_W-1:0] rx_data,
   input logic [1:0]        fc_mode,
   input logic [1:0]        wlen,
   input logic              xoff_irq_en,
   input logic              tx_at_boundary,
   input logic              tx_suspend,
   input logic              fifo_wr,
   input logic [CHAR_W-1:0] fifo_data,
   input logic              xoff_flag,
   input logic              irq,
   input logic [CHAR_W-1:0] off1_val
);
   logic [CHAR_W-1:0] cmask;
   assign cmask = {CHAR_W{1'b1}} >> (2'd3 - wlen);

   // R2: single-mode pause match is consumed and flags
   a_r2_pause_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && fc_mode == 2'd1 && (((rx_data ^ off1_val) & cmask) == '0))
      |=> (!fifo_wr && xoff_flag));

   // R6: suspend moves only after a boundary cycle (mode held)
   a_r6_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_at_boundary && fc_mode != 2'd0 && fc_mode != 2'd3)
      |=> ($stable(tx_suspend) || !$stable(fc_mode)));

   // R7: pass-through when disabled
   a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (fc_mode == 2'd0 || fc_mode == 2'd3))
      |=> (fifo_wr && fifo_data == $past(rx_data)));

   // R7: disabled mode never suspends
   a_r7_no_susp: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_mode == 2'd0) |-> !tx_suspend);

   // R8: interrupt only with flag and enable
   a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (xoff_flag && xoff_irq_en));

   // R5: any write stems from a strobe one or two cycles earlier
   a_r5_wr_origin: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> ($past(rx_valid) || $past(rx_valid, 2)));
endmodule

bind xonxoff_matcher xonxoff_matcher_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rx_valid       (rx_valid),
   .rx_data        (rx_data),
   .fc_mode        (fc_mode),
   .wlen           (wlen),
   .xoff_irq_en    (xoff_irq_en),
   .tx_at_boundary (tx_at_boundary),
   .tx_suspend     (tx_suspend),
   .fifo_wr        (fifo_wr),
   .fifo_data      (fifo_data),
   .xoff_flag      (xoff_flag),
   .irq            (irq),
   .off1_val       (reg_val[2])
);

// File: tb/xonxoff_matcher_tb_top.sv
module xonxoff_matcher_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;
   // {mode[29:28], ch[27:20], wr0[19], d0[18:11], wr1[10], d1[9:2], flag[1], susp[0]}
   localparam logic [29:0] VEC [NVEC] = '{
      {2'd1, 8'h41, 1'b1, 8'h41, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'd1, 8'h13, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
      {2'd1, 8'h42, 1'b1, 8'h42, 1'b0, 8'h00, 1'b1, 1'b1},
      {2'd1, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'd2, 8'h13, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'd2, 8'h14, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
      {2'd2, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
      {2'd2, 8'h55, 1'b1, 8'h11, 1'b1, 8'h55, 1'b1, 1'b1},
      {2'd2, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
      {2'd2, 8'h12, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'd2, 8'h13, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'd2, 8'h13, 1'b1, 8'h13, 1'b0, 8'h00, 1'b0, 1'b0},
      {2'd2, 8'h14, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
      {2'd0, 8'h13, 1'b1, 8'h13, 1'b0, 8'h00, 1'b1, 1'b0},
      {2'd0, 8'h11, 1'b1, 8'h11, 1'b0, 8'h00, 1'b1, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = '0;
   logic [7:0] reg_wdata = '0;
   logic [1:0] fc_mode = '0;
   logic [1:0] wlen = 2'd3;
   logic       xoff_irq_en = 1'b1;
   logic       tx_at_boundary = 1'b1;
   logic       tx_suspend, fifo_wr, xoff_flag, irq;
   logic [7:0] fifo_data;

   int n_tests = 0;
   int n_fail  = 0;
   logic       s_wr0, s_wr1;
   logic [7:0] s_d0, s_d1;

   always #(CLK_PERIOD/2) clk = ~clk;

   xonxoff_matcher dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .fc_mode(fc_mode), .wlen(wlen), .xoff_irq_en(xoff_irq_en),
      .tx_at_boundary(tx_at_boundary), .tx_suspend(tx_suspend),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .xoff_flag(xoff_flag), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] sel, input logic [7:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // strobe one char; capture write after edge k and k+1
   task automatic send(input logic [1:0] m, input logic [7:0] ch);
      @(negedge clk);
      fc_mode = m; rx_data = ch; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      s_wr0 = fifo_wr; s_d0 = fifo_data;
      @(negedge clk);
      s_wr1 = fifo_wr; s_d1 = fifo_data;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1: reset state
      check("R1 fifo_wr", 32'(fifo_wr), 0);
      check("R1 tx_suspend", 32'(tx_suspend), 0);
      check("R1 xoff_flag", 32'(xoff_flag), 0);
      check("R1 irq", 32'(irq), 0);
      rst_n = 1'b1;
      // R1/R10: registers are zero, so 0x00 matches pause and resume; pause wins
      send(2'd1, 8'h00);
      check("R10 dropped", 32'(s_wr0), 0);
      check("R10 flag", 32'(xoff_flag), 1);
      check("R10 suspend", 32'(tx_suspend), 1);
      do_reset();
      check("R1 flag after reset", 32'(xoff_flag), 0);
      check("R1 suspend after reset", 32'(tx_suspend), 0);

      wreg(2'd0, 8'h11); wreg(2'd1, 8'h12); wreg(2'd2, 8'h13); wreg(2'd3, 8'h14);

      // vector table: R2 R3 R4 R5 R7 R11
      for (int i = 0; i < NVEC; i++) begin
         logic [29:0] v;
         v = VEC[i];
         send(v[29:28], v[27:20]);
         check($sformatf("R11/R5 vec%0d wr0", i), 32'(s_wr0), 32'(v[19]));
         if (v[19]) check($sformatf("R11 vec%0d d0", i), 32'(s_d0), 32'(v[18:11]));
         check($sformatf("R5 vec%0d wr1", i), 32'(s_wr1), 32'(v[10]));
         if (v[10]) check($sformatf("R5 vec%0d d1", i), 32'(s_d1), 32'(v[9:2]));
         check($sformatf("R2/R3/R4 vec%0d flag", i), 32'(xoff_flag), 32'(v[1]));
         check($sformatf("R7/R4 vec%0d suspend", i), 32'(tx_suspend), 32'(v[0]));
      end

      // R6: gate by boundary
      tx_at_boundary = 1'b0;
      send(2'd1, 8'h11);
      check("R3 resume flag", 32'(xoff_flag), 0);
      // R9: 5-bit compare, 0xF3 matches 0x13
      wlen = 2'd0;
      send(2'd1, 8'hF3);
      check("R9 masked match dropped", 32'(s_wr0), 0);
      check("R9 masked match flag", 32'(xoff_flag), 1);
      repeat (3) @(negedge clk);
      check("R6 suspend held off", 32'(tx_suspend), 0);
      tx_at_boundary = 1'b1;
      @(negedge clk);
      tx_at_boundary = 1'b0;
      check("R6 suspend after boundary", 32'(tx_suspend), 1);
      // R9: forwarded data unmasked
      send(2'd1, 8'hF5);
      check("R9 forward wr", 32'(s_wr0), 1);
      check("R9 forward data", 32'(s_d0), 32'hF5);
      // R8: irq follows flag and enable
      check("R8 irq enabled", 32'(irq), 1);
      @(negedge clk);
      xoff_irq_en = 1'b0;
      #1;
      check("R8 irq disabled", 32'(irq), 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule